// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the software-facing half of an SMBus host. Software reaches it through a byte-wide port with a 3-bit offset. It holds a status byte, a control byte, a command code, a target address byte, two data bytes and a 32-byte block buffer. The buffer is reached one byte at a time through a port that steps an internal index on every access.

Software starts a transaction by writing the control register with its start bit set. The block then checks the protocol code. It issues a one-cycle request to an external bus engine, which carries the protocol, direction, 7-bit target, command and data. It keeps the busy flag up until the engine reports done. When the engine finishes, the block sets the completion flags, and on reads it captures the returned bytes. Status flags clear on a write of one. A latched device error blocks any further start until software clears it.

The engine reaches the block buffer through its own write port and read port, each with an index. Block reads fill the buffer through the write port, and block writes drain it through the read port. The bit-level bus signalling sits outside this block.

Top module: `smbh_host`

## Requirements
- R1: After reset every register, including the status byte at offset 0, reads 0, and `irq` and `req_valid` are 0.
- R2: A write to status (offset 0) clears exactly the flags written as 1 and leaves the rest. Status bits: 0 busy, 1 interrupt, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in-use, 7 byte done. The busy bit is read-only to software.
- R3: Any write to the status register returns the block buffer index to 0.
- R4: Control (offset 2) has bit0 interrupt enable, bits 3:1 protocol code and bit6 start. Start reads back as 0. A start with status busy and device error both clear, and a valid code (0 quick, 1 byte, 2 byte data, 3 word data, 5 block), pulses `req_valid` for exactly one cycle after the write edge. Busy reads 1 from that cycle on.
- R5: The request carries: direction from bit 0 of the address register (offset 4), target from its bits 7:1, the command (offset 3), `req_data` = {data1 (offset 6), data0 (offset 5)} with data1 high, and the block byte count taken from data0.
- R6: A successful engine completion clears busy and sets byte done and interrupt together, giving status 0x82. For a read other than quick, it also loads data0/data1 from the engine's low/high response bytes.
- R7: A failed engine completion clears busy and sets device error only, giving status 0x04.
- R8: A start with protocol code 4, 6 or 7 issues no request, leaves busy at 0 and sets device error.
- R9: While device error is set, a start issues no request and device error stays set.
- R10: A start while busy is ignored and issues no second request.
- R11: Each read or write of the block port (offset 7) accesses the buffer at the current index and then advances the index. The index saturates at 31.
- R12: The engine buffer ports write and read the same storage that the block port reaches.
- R13: `irq` is 1 exactly when the interrupt enable is 1 and status bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (steps the block index at offset 7) |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| irq | output | 1 | Interrupt request |
| req_valid | output | 1 | One-cycle transaction request |
| req_proto | output | 3 | Protocol code of the request |
| req_rd | output | 1 | 1 for a read transaction |
| req_target | output | 7 | 7-bit target address |
| req_cmd | output | 8 | Command code |
| req_data | output | 16 | {data1, data0} |
| req_count | output | 8 | Block byte count (data0) |
| eng_done | input | 1 | Engine completion pulse |
| eng_ok | input | 1 | Completion was successful |
| eng_rdata | input | 16 | Read response {high, low} |
| eng_we | input | 1 | Engine buffer write strobe |
| eng_widx | input | 5 | Engine buffer write index |
| eng_wbyte | input | 8 | Engine buffer write byte |
| eng_ridx | input | 5 | Engine buffer read index |
| eng_rbyte | output | 8 | Buffer byte at `eng_ridx` |

## Verification
Every register effect of a write is visible from the cycle after its clock edge. So the bench drives inputs on the falling edge and samples at the next falling edge: status flags, the `req_valid` pulse and its fields, busy and device error. A completion pulse updates status, `irq` and the captured data bytes one edge later, and the bench checks them at the falling edge after that pulse. `rdata` and `eng_rbyte` are combinational, so the bench samples them 1 ns after changing the offset or index. Only block-port accesses made with a strobe step the index, and register peeks leave the strobes low.

// File: rtl/smbh_pkg.sv
// Shared constants and helpers for the SMBus host register front end.
// Assumes a byte-wide register port with a 3-bit offset.
package smbh_pkg;

    typedef enum logic [2:0] {
        OFS_STAT = 3'd0,
        OFS_RSVD = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_CMD  = 3'd3,
        OFS_ADDR = 3'd4,
        OFS_D0   = 3'd5,
        OFS_D1   = 3'd6,
        OFS_BLK  = 3'd7
    } smbh_ofs_e;

    typedef enum logic [2:0] {
        PR_QUICK = 3'd0,
        PR_BYTE  = 3'd1,
        PR_BDATA = 3'd2,
        PR_WORD  = 3'd3,
        PR_BLOCK = 3'd5
    } smbh_proto_e;

    localparam int ST_BUSY  = 0;
    localparam int ST_INTR  = 1;
    localparam int ST_DERR  = 2;
    localparam int ST_DONE  = 7;

    localparam int CT_IEN   = 0;
    localparam int CT_PLO   = 1;
    localparam int CT_START = 6;

    // True for a protocol code the front end knows how to dispatch.
    function automatic logic proto_ok(input logic [2:0] p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WORD)  || (p == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smbh_status.sv
// Status flag register. Each bit is set by hardware or cleared by hardware
// or by a software write-one mask. A hardware set wins over any clear in
// the same cycle. Bits outside SW_CLR_MASK cannot be cleared by software.
module smbh_status #(
    parameter int          W           = 8,
    parameter logic [W-1:0] SW_CLR_MASK = 8'hFE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we,
    input  logic [W-1:0] sw_mask,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] stat
);

    logic [W-1:0] sw_clr;

    // Software clear mask, gated by the write strobe and the clearable set.
    always_comb sw_clr = sw_we ? (sw_mask & SW_CLR_MASK) : '0;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // One flag: set wins, otherwise clear on hardware or software request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat[b] <= 1'b0;
            else if (hw_set[b])
                stat[b] <= 1'b1;
            else if (hw_clr[b] || sw_clr[b])
                stat[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/smbh_blkbuf.sv
// Block data buffer with a host port that steps a saturating index and an
// engine port with explicit indices. If both sides write in the same cycle
// the engine write lands last. Assumes DEPTH is a power of two.
module smbh_blkbuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_rst,
    input  logic          host_we,
    input  logic          host_re,
    input  logic [DW-1:0] host_wbyte,
    output logic [DW-1:0] host_rbyte,
    output logic [IW-1:0] idx,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_widx,
    input  logic [DW-1:0] eng_wbyte,
    input  logic [IW-1:0] eng_ridx,
    output logic [DW-1:0] eng_rbyte
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];

    // Index pointer: reset on request, else step on access and hold at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n || idx_rst)
            idx <= '0;
        else if ((host_we || host_re) && idx != LAST)
            idx <= idx + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        // One buffer byte: cleared at reset, written by host then engine.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (eng_we && eng_widx == IW'(i))
                mem[i] <= eng_wbyte;
            else if (host_we && idx == IW'(i))
                mem[i] <= host_wbyte;
        end
    end

    // Combinational read taps for both sides.
    always_comb begin
        host_rbyte = mem[idx];
        eng_rbyte  = mem[eng_ridx];
    end

endmodule

// File: rtl/smbh_launch.sv
// Start decision and completion bookkeeping. A start is accepted only when
// the host is idle, no device error is latched and the code is valid. An
// unknown code raises a device error instead. The direction and protocol
// are held from the launch so the completion can load response bytes.
module smbh_launch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [2:0] trig_proto,
    input  logic       trig_rd,
    input  logic       busy,
    input  logic       derr,
    input  logic       done,
    input  logic       ok,
    output logic       launch,
    output logic       bad_code,
    output logic       req_valid,
    output logic       fin,
    output logic       fin_ok,
    output logic       fin_err,
    output logic       load_rsp
);
    import smbh_pkg::*;

    logic       pend_rd;
    logic [2:0] pend_proto;
    logic       gate;

    // Accept/reject decision for the current start request.
    always_comb begin
        gate     = trig && !busy && !derr;
        launch   = gate && proto_ok(trig_proto);
        bad_code = gate && !proto_ok(trig_proto);
        fin      = done && busy;
        fin_ok   = fin && ok;
        fin_err  = fin && !ok;
        load_rsp = fin_ok && pend_rd && (pend_proto != PR_QUICK);
    end

    // Request pulse, one cycle after an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_valid <= 1'b0;
        else
            req_valid <= launch;
    end

    // Direction and code held for the life of the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_rd    <= 1'b0;
            pend_proto <= '0;
        end else if (launch) begin
            pend_rd    <= trig_rd;
            pend_proto <= trig_proto;
        end
    end

endmodule

// File: rtl/smbh_host.sv
// SMBus host register front end: register decode, request fields toward
// the bus engine, status update and interrupt. Assumes one register access
// per cycle and that software leaves the request registers alone while busy.
module smbh_host #(
    parameter int DW        = 8,
    parameter int AW        = 3,
    parameter int BUF_DEPTH = 32,
    localparam int IW       = $clog2(BUF_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            irq,
    output logic            req_valid,
    output logic [2:0]      req_proto,
    output logic            req_rd,
    output logic [DW-2:0]   req_target,
    output logic [DW-1:0]   req_cmd,
    output logic [2*DW-1:0] req_data,
    output logic [DW-1:0]   req_count,
    input  logic            eng_done,
    input  logic            eng_ok,
    input  logic [2*DW-1:0] eng_rdata,
    input  logic            eng_we,
    input  logic [IW-1:0]   eng_widx,
    input  logic [DW-1:0]   eng_wbyte,
    input  logic [IW-1:0]   eng_ridx,
    output logic [DW-1:0]   eng_rbyte
);
    import smbh_pkg::*;

    logic [DW-1:0] stat_q;
    logic [DW-1:0] hw_set, hw_clr;
    logic          ien_q;
    logic [2:0]    proto_q;
    logic [DW-1:0] cmd_q, adr_q, d0_q, d1_q;
    logic          wr_stat, wr_ctrl, blk_wr, blk_rd, blk_acc, trig;
    logic [DW-1:0] blk_byte;
    logic [IW-1:0] blk_idx;
    logic          launch, bad_code, fin, fin_ok, fin_err, load_rsp;

    // Per-offset write and access strobes.
    always_comb begin
        wr_stat = wr_en && (addr == OFS_STAT);
        wr_ctrl = wr_en && (addr == OFS_CTRL);
        blk_wr  = wr_en && (addr == OFS_BLK);
        blk_rd  = rd_en && !wr_en && (addr == OFS_BLK);
        blk_acc = blk_wr || blk_rd;
        trig    = wr_ctrl && wdata[CT_START];
    end

    // Control register: interrupt enable and protocol code (start not kept).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= 1'b0;
            proto_q <= '0;
        end else if (wr_ctrl) begin
            ien_q   <= wdata[CT_IEN];
            proto_q <= wdata[CT_PLO +: 3];
        end
    end

    // Command and address registers, software-written only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            adr_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_CMD)  cmd_q <= wdata;
            if (addr == OFS_ADDR) adr_q <= wdata;
        end
    end

    // Data registers: a read response wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_q <= '0;
            d1_q <= '0;
        end else if (load_rsp) begin
            d0_q <= eng_rdata[DW-1:0];
            d1_q <= eng_rdata[2*DW-1:DW];
        end else if (wr_en) begin
            if (addr == OFS_D0) d0_q <= wdata;
            if (addr == OFS_D1) d1_q <= wdata;
        end
    end

    smbh_launch u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .trig_proto (wdata[CT_PLO +: 3]),
        .trig_rd    (adr_q[0]),
        .busy       (stat_q[ST_BUSY]),
        .derr       (stat_q[ST_DERR]),
        .done       (eng_done),
        .ok         (eng_ok),
        .launch     (launch),
        .bad_code   (bad_code),
        .req_valid  (req_valid),
        .fin        (fin),
        .fin_ok     (fin_ok),
        .fin_err    (fin_err),
        .load_rsp   (load_rsp)
    );

    // Hardware set/clear vectors for the status flags.
    always_comb begin
        hw_set          = '0;
        hw_clr          = '0;
        hw_set[ST_BUSY] = launch;
        hw_set[ST_INTR] = fin_ok;
        hw_set[ST_DONE] = fin_ok;
        hw_set[ST_DERR] = bad_code || fin_err;
        hw_clr[ST_BUSY] = fin;
    end

    smbh_status #(
        .W           (DW),
        .SW_CLR_MASK (8'hFE)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (wr_stat),
        .sw_mask (wdata),
        .hw_set  (hw_set),
        .hw_clr  (hw_clr),
        .stat    (stat_q)
    );

    smbh_blkbuf #(
        .DW    (DW),
        .DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_rst    (wr_stat),
        .host_we    (blk_wr),
        .host_re    (blk_rd),
        .host_wbyte (wdata),
        .host_rbyte (blk_byte),
        .idx        (blk_idx),
        .eng_we     (eng_we),
        .eng_widx   (eng_widx),
        .eng_wbyte  (eng_wbyte),
        .eng_ridx   (eng_ridx),
        .eng_rbyte  (eng_rbyte)
    );

    // Request fields toward the bus engine.
    always_comb begin
        req_proto  = proto_q;
        req_rd     = adr_q[0];
        req_target = adr_q[DW-1:1];
        req_cmd    = cmd_q;
        req_data   = {d1_q, d0_q};
        req_count  = d0_q;
        irq        = ien_q && stat_q[ST_INTR];
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (addr)
            OFS_STAT: rdata = stat_q;
            OFS_CTRL: rdata = {4'b0, proto_q, ien_q};
            OFS_CMD:  rdata = cmd_q;
            OFS_ADDR: rdata = adr_q;
            OFS_D0:   rdata = d0_q;
            OFS_D1:   rdata = d1_q;
            OFS_BLK:  rdata = blk_byte;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/smbh_host_chk.sv
// Temporal checks on the host front end, bound to every smbh_host instance.
module smbh_host_chk #(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          req_valid,
    input logic [DW-1:0] stat,
    input logic          eng_done,
    input logic          eng_ok,
    input logic          blk_acc,
    input logic [IW-1:0] blk_idx
);
    localparam logic [IW-1:0] LAST = '1;

    // R4: the request is a single-cycle pulse.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R4: busy is up while a request is presented.
    a_r4_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> stat[0]);

    // R10: no request follows a cycle in which the host was already busy.
    a_r10_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$past(stat[0]));

    // R9: no request follows a cycle with device error latched.
    a_r9_derr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$past(stat[2]));

    // R6: a good completion raises byte done and interrupt and drops busy.
    a_r6_ok_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_ok && stat[0]) |=> (stat[1] && stat[7] && !stat[0]));

    // R7: a failed completion raises device error.
    a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !eng_ok && stat[0]) |=> (stat[2] && !stat[0]));

    // R2: software cannot clear busy.
    a_r2_busy_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && stat[0] && !eng_done) |=> stat[0]);

    // R3: a status write returns the index to zero.
    a_r3_idx_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> (blk_idx == '0));

    // R11: the index holds at its last position.
    a_r11_idx_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_acc && blk_idx == LAST && !(wr_en && addr == '0)) |=> (blk_idx == LAST));

endmodule

bind smbh_host smbh_host_chk #(.DW(DW), .AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .req_valid (req_valid),
    .stat      (stat_q),
    .eng_done  (eng_done),
    .eng_ok    (eng_ok),
    .blk_acc   (blk_acc),
    .blk_idx   (blk_idx)
);

// File: tb/smbh_host_bench.sv
// Directed and seeded-random checks of the SMBus host front end.
module smbh_host_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq, req_valid, req_rd;
    logic [2:0]  req_proto;
    logic [6:0]  req_target;
    logic [7:0]  req_cmd, req_count, eng_rbyte;
    logic [15:0] req_data;
    logic        eng_done = 1'b0, eng_ok = 1'b0, eng_we = 1'b0;
    logic [15:0] eng_rdata = '0;
    logic [4:0]  eng_widx = '0, eng_ridx = '0;
    logic [7:0]  eng_wbyte = '0;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    smbh_host u_smbh_host (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .req_valid(req_valid),
        .req_proto(req_proto), .req_rd(req_rd), .req_target(req_target),
        .req_cmd(req_cmd), .req_data(req_data), .req_count(req_count),
        .eng_done(eng_done), .eng_ok(eng_ok), .eng_rdata(eng_rdata),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wbyte(eng_wbyte),
        .eng_ridx(eng_ridx), .eng_rbyte(eng_rbyte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        rd_en = 1'b0; addr = a; #1; v = rdata;
    endtask

    task automatic blk_read(output logic [7:0] v);
        @(negedge clk); addr = 3'd7; rd_en = 1'b1; #1; v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic respond(input bit ok, input logic [15:0] d);
        @(negedge clk); eng_done = 1'b1; eng_ok = ok; eng_rdata = d;
        @(negedge clk); eng_done = 1'b0;
    endtask

    function automatic bit valid_code(input logic [2:0] p);
        return p == 0 || p == 1 || p == 2 || p == 3 || p == 5;
    endfunction

    function automatic logic [7:0] ctl(input bit ien, input logic [2:0] p, input bit go);
        return {1'b0, go, 2'b00, p, ien};
    endfunction

    function automatic logic [7:0] stat_after(input bit ok);
        return ok ? 8'h82 : 8'h04;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(3'd0, v); chk(v == 8'h00, "R1 status", v, 0);
        peek(3'd2, v); chk(v == 8'h00, "R1 control", v, 0);
        chk(irq == 0 && req_valid == 0, "R1 irq/req", {irq, req_valid}, 0);

        // R4/R5: word write launch with field check
        wr(3'd3, 8'h5A); wr(3'd4, 8'hA4); wr(3'd5, 8'h34); wr(3'd6, 8'h12);
        wr(3'd2, ctl(1, 3'd3, 1));
        chk(req_valid == 1, "R4 pulse", req_valid, 1);
        chk(req_proto == 3 && req_rd == 0 && req_target == 7'h52, "R5 fields",
            {req_proto, req_rd, req_target}, {3'd3, 1'b0, 7'h52});
        chk(req_data == 16'h1234 && req_cmd == 8'h5A && req_count == 8'h34, "R5 data",
            req_data, 16'h1234);
        peek(3'd0, v); chk(v == 8'h01, "R4 busy", v, 1);
        peek(3'd2, v); chk(v == 8'h07, "R4 start reads 0", v, 7);
        @(negedge clk);
        chk(req_valid == 0, "R4 single cycle", req_valid, 0);

        // R10: start while busy ignored
        wr(3'd2, ctl(1, 3'd3, 1));
        chk(req_valid == 0, "R10 busy start", req_valid, 0);
        // R2: busy cannot be cleared by software
        wr(3'd0, 8'h01);
        peek(3'd0, v); chk(v == 8'h01, "R2 busy read-only", v, 1);

        // R6/R13: good completion
        respond(1, 16'hBEEF);
        peek(3'd0, v); chk(v == 8'h82, "R6 status", v, 8'h82);
        chk(irq == 1, "R13 irq on", irq, 1);
        // R2: clear only byte done
        wr(3'd0, 8'h80);
        peek(3'd0, v); chk(v == 8'h02, "R2 partial clear", v, 2);
        wr(3'd0, 8'h02);
        chk(irq == 0, "R13 irq off", irq, 0);

        // R6: byte-data read loads data0/data1
        wr(3'd4, 8'h61);
        wr(3'd2, ctl(0, 3'd2, 1));
        chk(req_rd == 1, "R5 read dir", req_rd, 1);
        respond(1, 16'hC3A5);
        peek(3'd5, v); chk(v == 8'hA5, "R6 data0 load", v, 8'hA5);
        peek(3'd6, v); chk(v == 8'hC3, "R6 data1 load", v, 8'hC3);
        chk(irq == 0, "R13 irq masked", irq, 0);
        wr(3'd0, 8'hFF);

        // R7: failed completion
        wr(3'd2, ctl(0, 3'd1, 1));
        respond(0, 16'h0);
        peek(3'd0, v); chk(v == 8'h04, "R7 status", v, 4);

        // R9: start blocked by latched device error
        wr(3'd2, ctl(0, 3'd0, 1));
        chk(req_valid == 0, "R9 no req", req_valid, 0);
        peek(3'd0, v); chk(v == 8'h04, "R9 derr held", v, 4);
        wr(3'd0, 8'h04);

        // R8: unknown code
        wr(3'd2, ctl(0, 3'd6, 1));
        chk(req_valid == 0, "R8 no req", req_valid, 0);
        peek(3'd0, v); chk(v == 8'h04, "R8 derr set", v, 4);
        wr(3'd0, 8'hFF);

        // R11: block port stepping and saturation
        for (int i = 0; i < 33; i++) wr(3'd7, 8'(i + 1));
        wr(3'd0, 8'h00);
        for (int i = 0; i < 33; i++) begin
            blk_read(v);
            chk(v == ((i < 31) ? 8'(i + 1) : 8'd33), "R11 block byte", v, (i < 31) ? i + 1 : 33);
        end
        // R12: engine ports share the buffer
        eng_ridx = 5'd5; #1;
        chk(eng_rbyte == 8'd6, "R12 engine read", eng_rbyte, 6);
        @(negedge clk); eng_we = 1'b1; eng_widx = 5'd2; eng_wbyte = 8'hAA;
        @(negedge clk); eng_we = 1'b0;
        // R3: status write rewinds the index
        wr(3'd0, 8'h00);
        blk_read(v); chk(v == 8'd1, "R3 index zero", v, 1);
        blk_read(v); blk_read(v);
        chk(v == 8'hAA, "R12 engine write", v, 8'hAA);
        wr(3'd0, 8'hFF);

        // Random transactions against bench-computed expectations
        for (int k = 0; k < 60; k++) begin
            logic [2:0] p; logic [7:0] a, c, d0, d1; bit ien, ok; logic [15:0] rsp;
            p = 3'($urandom); a = 8'($urandom); c = 8'($urandom);
            d0 = 8'($urandom); d1 = 8'($urandom); ien = 1'($urandom);
            ok = 1'($urandom); rsp = 16'($urandom);
            wr(3'd3, c); wr(3'd4, a); wr(3'd5, d0); wr(3'd6, d1);
            wr(3'd2, ctl(ien, p, 1));
            if (valid_code(p)) begin
                chk(req_valid == 1 && req_proto == p && req_rd == a[0] &&
                    req_target == a[7:1] && req_cmd == c, "R5 random fields",
                    {req_valid, req_proto, req_target}, {1'b1, p, a[7:1]});
                chk(req_data == {d1, d0}, "R5 random data", req_data, {d1, d0});
                respond(ok, rsp);
                peek(3'd0, v); chk(v == stat_after(ok), "R6 random status", v, stat_after(ok));
                chk(irq == (ien && ok), "R13 random irq", irq, ien && ok);
                if (ok && a[0] && p != 0) begin
                    peek(3'd5, v); chk(v == rsp[7:0], "R6 random data0", v, rsp[7:0]);
                end
            end else begin
                chk(req_valid == 0, "R8 random no req", req_valid, 0);
                peek(3'd0, v); chk(v == 8'h04, "R8 random derr", v, 4);
            end
            wr(3'd0, 8'hFF);
        end

        summary();
    end

endmodule